// File: doc/BRIEF.md
# Vector Escape Prefix Field Extractor

This block sits at the front of an instruction decoder and looks at one candidate escape byte together with the bytes that follow it. It decides whether the escape starts a two-byte (0xC5) or three-byte (0xC4) vector extension prefix, or whether it should be passed on as an ordinary opcode. When a prefix is recognised, the block extracts its fields:

- the register-extension bits R, X, B and W;
- the vector length L;
- the extra source register number;
- the opcode map and the implied legacy prefix selector;
- a combined table index that the next lookup stage uses.

Reserved map values raise an error flag.

Several fields travel inverted on the wire, and the block complements them. Outside 64-bit mode, the escape counts as a prefix only when the top two bits of the next byte are both set. A second register number carried in the high nibble of an immediate byte is also decoded, with a width that depends on the mode.

Each decoded result is captured into an output holding register. It stays presented with a valid strobe until the consumer acknowledges it. A new input is accepted only while the holding register is free or is being acknowledged in the same cycle.

Top module: `vex_field_extract`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: In 64-bit mode (mode64=1), escape 0xC5 gives is_vex=1 with nbytes=2, and escape 0xC4 gives is_vex=1 with nbytes=3. Any other escape byte gives is_vex=0 with nbytes=0, tbl_idx=0, map_err=0, and R, X, B, W, L, vreg, map_sel and pp all 0.
- R3: Outside 64-bit mode (mode64=0), 0xC4 or 0xC5 is a prefix only when bits 7:6 of pay1 are both 1. Otherwise the result is the not-prefix result of R2, with table index 0.
- R4: Two-byte form fields:
  - R = ~pay1[7] and L = pay1[2];
  - vreg = ~pay1[6:3] (4-bit complement) and pp = pay1[1:0];
  - X, B and W are 0, and map_sel = 1.
- R5: Two-byte form index: tbl_idx = 1 | (pp << 2), and map_err = 0.
- R6: Three-byte form fields:
  - R, X and B are ~pay1[7], ~pay1[6] and ~pay1[5];
  - map_sel = pay1[4:0];
  - W = pay2[7] and L = pay2[2];
  - vreg = ~pay2[6:3] and pp = pay2[1:0].
- R7: Three-byte form with map_sel in 1..3: tbl_idx = (pp << 2) | map_sel[1:0], and map_err = 0.
- R8: Three-byte form with map_sel equal to 0 or greater than 3: map_err = 1 and tbl_idx = 0. The other fields still follow R6.
- R9: imm_reg is imm_byte[7:4] in 64-bit mode and {1'b0, imm_byte[6:4]} otherwise, whatever the escape byte is.
- R10: While out_valid=1 and out_ack=0, in_ready is 0, out_valid stays 1, every result output holds its value, and in_valid is ignored.
- R11: out_ack=1 with no new input clears out_valid on the next cycle. out_ack=1 together with in_valid=1 replaces the held result with the new one on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 1 when decoding in 64-bit mode |
| in_valid | input | 1 | Input bytes present |
| in_ready | output | 1 | Block can take an input this cycle |
| esc_byte | input | 8 | Candidate escape byte |
| pay1 | input | 8 | Byte after the escape (also the lookahead byte) |
| pay2 | input | 8 | Second byte after the escape |
| imm_byte | input | 8 | Immediate byte carrying a register in bits 7:4 |
| out_valid | output | 1 | Held result present |
| out_ack | input | 1 | Consumer takes the held result |
| is_vex | output | 1 | Escape was a vector prefix |
| nbytes | output | 2 | Prefix bytes consumed: 0, 2 or 3 |
| rex_r | output | 1 | Effective R bit |
| rex_x | output | 1 | Effective X bit |
| rex_b | output | 1 | Effective B bit |
| rex_w | output | 1 | Effective W bit |
| vlen | output | 1 | Vector length bit L |
| vreg | output | 4 | Extra source register number |
| map_sel | output | 5 | Opcode map selector |
| pp | output | 2 | Implied prefix selector |
| tbl_idx | output | 4 | Combined table index |
| map_err | output | 1 | Reserved map value seen |
| imm_reg | output | 4 | Register number from immediate byte |

## Verification
Every value of the byte after the escape is applied in both modes, with both prefix escapes and with two ordinary escape bytes, each under four second-payload patterns:

- The sweep over the top two bits of that byte separates the 64-bit acceptance rule from the outside-64-bit rule.
- All five map-field values are covered, including reserved 0 and values above 3, which tells valid index forming apart from the error path.
- The payload patterns 0x00, 0xFF, 0xA5 and 0x5A toggle every inverted bit in both polarities, so a missing complement or a swapped bit shows up.

A separate sequence holds a result while new inputs are offered, then acknowledges with and without a simultaneous input.

// File: rtl/vex_pkg.sv
package vex_pkg;

    localparam int BYTE_W = 8;
    localparam int REG_W  = 4;
    localparam int IDX_W  = 4;
    localparam int MAP_W  = 5;
    localparam int PP_W   = 2;

    localparam logic [BYTE_W-1:0] ESC_TWO   = 8'hC5;
    localparam logic [BYTE_W-1:0] ESC_THREE = 8'hC4;
    localparam logic [MAP_W-1:0]  MAP_LAST  = 5'd3;

    typedef enum logic [1:0] {
        FORM_NONE  = 2'd0,
        FORM_TWO   = 2'd2,
        FORM_THREE = 2'd3
    } vex_form_e;

    typedef struct packed {
        logic              is_vex;
        logic [1:0]        nbytes;
        logic              r;
        logic              x;
        logic              b;
        logic              w;
        logic              l;
        logic [REG_W-1:0]  vreg;
        logic [MAP_W-1:0]  map_sel;
        logic [PP_W-1:0]   pp;
        logic [IDX_W-1:0]  idx;
        logic              map_err;
        logic [REG_W-1:0]  imm_reg;
    } vex_info_t;

    function automatic logic [REG_W-1:0] imm_reg_of(input logic [BYTE_W-1:0] imm,
                                                     input logic m64);
        logic [REG_W-1:0] nib;
        nib = imm[BYTE_W-1 -: REG_W];
        return m64 ? nib : {1'b0, nib[REG_W-2:0]};
    endfunction

    function automatic logic map_reserved(input logic [MAP_W-1:0] m);
        return (m == '0) || (m > MAP_LAST);
    endfunction

endpackage

// File: rtl/vex_form_detect.sv
module vex_form_detect
    import vex_pkg::*;
(
    input  logic [BYTE_W-1:0] esc,
    input  logic [BYTE_W-1:0] nxt,
    input  logic              m64,
    output vex_form_e         form
);
    logic escape_hit;
    logic mode_ok;

    always_comb begin
        escape_hit = (esc == ESC_TWO) || (esc == ESC_THREE);
        mode_ok    = m64 || (nxt[BYTE_W-1:BYTE_W-2] == 2'b11);
        if (!(escape_hit && mode_ok))
            form = FORM_NONE;
        else if (esc == ESC_TWO)
            form = FORM_TWO;
        else
            form = FORM_THREE;
    end
endmodule

// File: rtl/vex_field_decode.sv
module vex_field_decode
    import vex_pkg::*;
(
    input  vex_form_e         form,
    input  logic [BYTE_W-1:0] p1,
    input  logic [BYTE_W-1:0] p2,
    input  logic [BYTE_W-1:0] imm,
    input  logic              m64,
    output vex_info_t         info
);
    logic [BYTE_W-1:0] last_b;

    always_comb begin
        info         = '0;
        info.imm_reg = imm_reg_of(imm, m64);
        last_b       = (form == FORM_TWO) ? p1 : p2;
        if (form != FORM_NONE) begin
            info.is_vex = 1'b1;
            info.r      = ~p1[7];
            info.l      = last_b[2];
            info.vreg   = ~last_b[6:3];
            info.pp     = last_b[PP_W-1:0];
        end
        case (form)
            FORM_TWO: begin
                info.nbytes  = 2'd2;
                info.map_sel = MAP_W'(1);
                info.idx     = IDX_W'(1) | (IDX_W'(info.pp) << 2);
            end
            FORM_THREE: begin
                info.nbytes  = 2'd3;
                info.x       = ~p1[6];
                info.b       = ~p1[5];
                info.w       = p2[7];
                info.map_sel = p1[MAP_W-1:0];
                info.map_err = map_reserved(info.map_sel);
                info.idx     = info.map_err ? '0
                             : ((IDX_W'(info.pp) << 2) | IDX_W'(info.map_sel[1:0]));
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vex_out_hold.sv
module vex_out_hold
    import vex_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  vex_info_t d,
    input  logic      ack,
    output logic      ready,
    output logic      valid,
    output vex_info_t q
);
    logic take;

    assign ready = !valid || ack;
    assign take  = in_valid && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            q     <= '0;
        end else if (take) begin
            valid <= 1'b1;
            q     <= d;
        end else if (ack) begin
            valid <= 1'b0;
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (valid && !ack) |=> (valid && $stable(q)));

    assert_ack_R11: assert property (@(posedge clk) disable iff (rst)
        (valid && ack && !in_valid) |=> !valid);
endmodule

// File: rtl/vex_field_extract.sv
module vex_field_extract
    import vex_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode64,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] esc_byte,
    input  logic [BYTE_W-1:0] pay1,
    input  logic [BYTE_W-1:0] pay2,
    input  logic [BYTE_W-1:0] imm_byte,
    output logic              out_valid,
    input  logic              out_ack,
    output logic              is_vex,
    output logic [1:0]        nbytes,
    output logic              rex_r,
    output logic              rex_x,
    output logic              rex_b,
    output logic              rex_w,
    output logic              vlen,
    output logic [REG_W-1:0]  vreg,
    output logic [MAP_W-1:0]  map_sel,
    output logic [PP_W-1:0]   pp,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic              map_err,
    output logic [REG_W-1:0]  imm_reg
);
    vex_form_e form;
    vex_info_t dec;
    vex_info_t held;

    vex_form_detect u_detect (
        .esc  (esc_byte),
        .nxt  (pay1),
        .m64  (mode64),
        .form (form)
    );

    vex_field_decode u_decode (
        .form (form),
        .p1   (pay1),
        .p2   (pay2),
        .imm  (imm_byte),
        .m64  (mode64),
        .info (dec)
    );

    vex_out_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .d        (dec),
        .ack      (out_ack),
        .ready    (in_ready),
        .valid    (out_valid),
        .q        (held)
    );

    assign is_vex  = held.is_vex;
    assign nbytes  = held.nbytes;
    assign rex_r   = held.r;
    assign rex_x   = held.x;
    assign rex_b   = held.b;
    assign rex_w   = held.w;
    assign vlen    = held.l;
    assign vreg    = held.vreg;
    assign map_sel = held.map_sel;
    assign pp      = held.pp;
    assign tbl_idx = held.idx;
    assign map_err = held.map_err;
    assign imm_reg = held.imm_reg;

    assert_legacy_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !is_vex) |-> (tbl_idx == '0 && nbytes == 2'd0 && !map_err));

    assert_err_form_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && map_err) |-> (is_vex && nbytes == 2'd3 && tbl_idx == '0));

    assert_two_form_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && nbytes == 2'd2) |-> (!rex_x && !rex_b && !rex_w && map_sel == MAP_W'(1)));

    assert_vex_len_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && is_vex) |-> (nbytes == 2'd2 || nbytes == 2'd3));
endmodule

// File: tb/vex_field_extract_test.sv
module vex_field_extract_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode64 = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] esc_byte = 8'h00, pay1 = 8'h00, pay2 = 8'h00, imm_byte = 8'h00;
    logic out_valid;
    logic out_ack = 1'b0;
    logic is_vex, rex_r, rex_x, rex_b, rex_w, vlen, map_err;
    logic [1:0] nbytes, pp;
    logic [3:0] vreg, tbl_idx, imm_reg;
    logic [4:0] map_sel;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    vex_field_extract uut (
        .clk(clk), .rst(rst), .mode64(mode64), .in_valid(in_valid), .in_ready(in_ready),
        .esc_byte(esc_byte), .pay1(pay1), .pay2(pay2), .imm_byte(imm_byte),
        .out_valid(out_valid), .out_ack(out_ack), .is_vex(is_vex), .nbytes(nbytes),
        .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b), .rex_w(rex_w), .vlen(vlen),
        .vreg(vreg), .map_sel(map_sel), .pp(pp), .tbl_idx(tbl_idx), .map_err(map_err),
        .imm_reg(imm_reg)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic m, input logic [7:0] e, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] i);
        @(negedge clk);
        mode64 = m; esc_byte = e; pay1 = a; pay2 = b; imm_byte = i; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic verify(input logic m, input logic [7:0] e, input logic [7:0] a,
                          input logic [7:0] b, input logic [7:0] i);
        logic ev, two, three;
        logic [1:0] enb, epp;
        logic er, ex, eb, ew, el, eerr;
        logic [3:0] evr, eidx, eimm;
        logic [4:0] emap;
        ev = (e == 8'hC4 || e == 8'hC5) && (m || a[7:6] == 2'b11);
        two = ev && e == 8'hC5;
        three = ev && e == 8'hC4;
        enb = two ? 2'd2 : (three ? 2'd3 : 2'd0);
        er = ev ? ~a[7] : 1'b0;
        ex = three ? ~a[6] : 1'b0;
        eb = three ? ~a[5] : 1'b0;
        ew = three ? b[7] : 1'b0;
        el = two ? a[2] : (three ? b[2] : 1'b0);
        evr = two ? ~a[6:3] : (three ? ~b[6:3] : 4'd0);
        epp = two ? a[1:0] : (three ? b[1:0] : 2'd0);
        emap = two ? 5'd1 : (three ? a[4:0] : 5'd0);
        eerr = three && (a[4:0] == 5'd0 || a[4:0] > 5'd3);
        if (two) eidx = 4'd1 + 4'(epp) * 4'd4;
        else if (three && !eerr) eidx = 4'(epp) * 4'd4 + 4'(a[1:0]);
        else eidx = 4'd0;
        eimm = m ? i[7:4] : {1'b0, i[6:4]};
        // R2 R3 classification and bytes consumed
        check("R2/R3 class", {29'd0, out_valid, is_vex, 1'b0} | 32'(nbytes) << 8,
              {29'd0, 1'b1, ev, 1'b0} | 32'(enb) << 8);
        // R4 R6 fields
        check("R4/R6 fields", {15'd0, er, ex, eb, ew, el, evr, emap, epp} ,
              {15'd0, rex_r, rex_x, rex_b, rex_w, vlen, vreg, map_sel, pp});
        // R5 R7 R8 index and error
        check("R5/R7/R8 index", {27'd0, map_err, tbl_idx}, {27'd0, eerr, eidx});
        // R9 immediate register
        check("R9 imm_reg", 32'(imm_reg), 32'(eimm));
    endtask

    task automatic ack_one();
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
    endtask

    initial begin
        logic [7:0] escs [4];
        logic [7:0] p2s [4];
        escs = '{8'hC4, 8'hC5, 8'h62, 8'h8F};
        p2s = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 in_ready", 32'(in_ready), 32'd1);

        for (int m = 0; m < 2; m++)
            for (int e = 0; e < 4; e++)
                for (int a = 0; a < 256; a++)
                    for (int k = 0; k < 4; k++) begin
                        drive(m[0], escs[e], 8'(a), p2s[k], 8'(a) ^ p2s[k]);
                        verify(m[0], escs[e], 8'(a), p2s[k], 8'(a) ^ p2s[k]);
                        ack_one();
                    end

        // R10 hold while not acknowledged
        drive(1'b1, 8'hC4, 8'h62, 8'h9D, 8'hB0);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            check("R10 in_ready", 32'(in_ready), 32'd0);
            esc_byte = 8'hC5; pay1 = 8'hFF; pay2 = 8'h00; imm_byte = 8'h10; in_valid = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        verify(1'b1, 8'hC4, 8'h62, 8'h9D, 8'hB0);

        // R11 acknowledge together with new input
        mode64 = 1'b0; esc_byte = 8'hC5; pay1 = 8'hF9; pay2 = 8'h00; imm_byte = 8'hF0;
        in_valid = 1'b1; out_ack = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; out_ack = 1'b0;
        verify(1'b0, 8'hC5, 8'hF9, 8'h00, 8'hF0);
        check("R11 idx after replace", 32'(tbl_idx), 32'd5);

        // R11 acknowledge alone clears
        ack_one();
        check("R11 cleared", 32'(out_valid), 32'd0);
        check("R11 ready", 32'(in_ready), 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule